// File: doc/BRIEF.md
# Microcoded Memory Timing Sequencer

This block drives the control pins of an external memory from a small program held in on-chip RAM. Software loads 32-bit control words through a write port. Each word describes one bus cycle. For each of four select lines, the word gives the pin level in each of the four quarter-phases of that cycle. It also gives the levels of twelve general-purpose lines. Two flag bits per word ask the engine to stall on an external wait pin, or mark the word as the final one of a sequence.

The system clock runs at four times the bus rate. A free-running two-bit phase counter marks the quarter-phases, and phase 3 closes each bus cycle. A run can be requested from four sources: an exception, a periodic timer, a software command and a memory access. Each source has its own start index. At a bus-cycle boundary the engine takes the highest-priority pending request, latches the word at that source's start index, and plays it. At each later boundary it moves to the next word, until it finishes a word marked final. While the engine is idle, every select pin rests high.

Top module: `pinseq_engine`

## Requirements
- R1: While busy, in quarter-phase p, `sel_n[i]` equals bit 4*i+p of the current word, and `gpl` equals bits [27:16] of that word. Both come from a copy of the word latched at the bus-cycle boundary.
- R2: After reset and whenever `busy` is low, `sel_n` is all ones, `gpl` is zero and `done` is low.
- R3: `qphase` starts at 0 after reset and increases by one every clock, wrapping from 3 to 0. A run's first word appears with `qphase` equal to 0.
- R4: A run starts at index `start_exc`, `start_tmr` or `start_mem` for those sources. A software run starts at the `sw_idx` value captured with its `sw_run` pulse.
- R5: After a word whose bit 29 (final flag) is 0, the index advances by one, wrapping from 63 to 0. After a word whose final flag is 1, the run ends: `busy` falls and `done` is high for exactly one clock.
- R6: For a word whose bit 28 (wait-enable) is 1, the engine samples `wait_in` through a two-flop synchronizer at the word's closing boundary. If the synchronized value is high, the word repeats for another bus cycle. A level raised three clocks before the boundary still holds the word. A level raised two clocks before it does not.
- R7: For a word whose wait-enable bit is 0, `wait_in` has no effect.
- R8: When several requests are pending, the grant order is exception, then timer, then software, then memory. A request that arrives during a run stays pending and is served after the run ends.
- R9: A RAM write is ignored while `busy` is high. A write while idle replaces the word.
- R10: Bits [31:30] of a word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4x bus rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | RAM write strobe |
| wr_addr | input | 6 | RAM write index |
| wr_data | input | 32 | Control word to store |
| req_exc | input | 1 | Exception request pulse |
| req_tmr | input | 1 | Periodic timer request pulse |
| sw_run | input | 1 | Software run command pulse |
| sw_idx | input | 6 | Start index captured with `sw_run` |
| req_mem | input | 1 | Memory access request pulse |
| start_exc | input | 6 | Start index for exception runs |
| start_tmr | input | 6 | Start index for timer runs |
| start_mem | input | 6 | Start index for memory runs |
| wait_in | input | 1 | Asynchronous external wait |
| sel_n | output | 4 | Select pins, active low |
| gpl | output | 12 | General-purpose lines |
| qphase | output | 2 | Current quarter-phase |
| busy | output | 1 | A run is active |
| done | output | 1 | One-clock pulse after a run ends |

## Verification
The bench builds the block with its default 6-bit index, so the RAM has 64 words. This makes it practical to launch a software run from every start index and compare every quarter-phase of every word against values computed in the bench. Runs that start near the top of the array wrap through index 63 to 0. The bench also places wait-pin edges three and two clocks before a wait-enabled boundary, which exposes the exact synchronizer latency. Four requests raised in the same clock show the grant order.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

    localparam int IDX_W  = 6;
    localparam int NSEL   = 4;
    localparam int NPH    = 4;
    localparam int PH_W   = $clog2(NPH);
    localparam int GPL_W  = 12;
    localparam int RSV_W  = 2;
    localparam int SEL_W  = NSEL * NPH;
    localparam int WORD_W = RSV_W + 2 + GPL_W + SEL_W;
    localparam int NSRC   = 4;

    // Control word: select phase bits in the low field, line i phase p at 4*i+p
    typedef struct packed {
        logic [RSV_W-1:0] rsv;
        logic             last;
        logic             waen;
        logic [GPL_W-1:0] gpl;
        logic [SEL_W-1:0] sel;
    } ctl_word_t;

    // Request slots; a lower number wins arbitration
    typedef enum logic [1:0] {
        SRC_EXC = 2'd0,
        SRC_TMR = 2'd1,
        SRC_SW  = 2'd2,
        SRC_MEM = 2'd3
    } src_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_t;

    function automatic logic [NSEL-1:0] sel_slice(input ctl_word_t w,
                                                   input logic [PH_W-1:0] ph);
        logic [NSEL-1:0] r;
        for (int i = 0; i < NSEL; i++) begin
            r[i] = w.sel[i*NPH + int'(ph)];
        end
        return r;
    endfunction

endpackage

// File: rtl/pinseq_store.sv
module pinseq_store #(
    parameter int IDX_W  = pinseq_pkg::IDX_W,
    parameter int WORD_W = pinseq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read: the word is latched by the engine at the boundary
    assign rdata = mem[raddr];

endmodule

// File: rtl/pinseq_sync.sv
module pinseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= {s_q[STAGES-2:0], d};
        end
    end

    assign q = s_q[STAGES-1];

endmodule

// File: rtl/pinseq_arb.sv
module pinseq_arb
    import pinseq_pkg::*;
#(
    parameter int IDX_W = pinseq_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req,
    input  logic [IDX_W-1:0] sw_idx_in,
    input  logic [IDX_W-1:0] start_exc,
    input  logic [IDX_W-1:0] start_tmr,
    input  logic [IDX_W-1:0] start_mem,
    input  logic             take,
    output logic             avail,
    output logic [IDX_W-1:0] start_idx
);
    logic [NSRC-1:0]  pend_q;
    logic [NSRC-1:0]  lower;
    logic [NSRC-1:0]  pick;
    logic [IDX_W-1:0] sw_idx_q;
    src_t             win;

    // Fixed priority: slot g wins when no lower slot is pending
    assign lower[0] = 1'b0;
    assign pick[0]  = pend_q[0];
    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_pri
            assign lower[g] = lower[g-1] | pend_q[g-1];
            assign pick[g]  = pend_q[g] & ~lower[g];
        end
    endgenerate

    always_comb begin
        win = SRC_MEM;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (pick[k]) begin
                win = src_t'(k);
            end
        end
    end

    always_comb begin
        unique case (win)
            SRC_EXC: start_idx = start_exc;
            SRC_TMR: start_idx = start_tmr;
            SRC_SW:  start_idx = sw_idx_q;
            default: start_idx = start_mem;
        endcase
    end

    assign avail = |pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            sw_idx_q <= '0;
        end else begin
            // A fresh pulse in the grant cycle keeps the slot pending
            pend_q <= (pend_q & ~(take ? pick : '0)) | req;
            if (req[SRC_SW]) begin
                sw_idx_q <= sw_idx_in;
            end
        end
    end

endmodule

// File: rtl/pinseq_engine.sv
module pinseq_engine
    import pinseq_pkg::*;
#(
    parameter int IDX_W = pinseq_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              req_exc,
    input  logic              req_tmr,
    input  logic              sw_run,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              req_mem,
    input  logic [IDX_W-1:0]  start_exc,
    input  logic [IDX_W-1:0]  start_tmr,
    input  logic [IDX_W-1:0]  start_mem,
    input  logic              wait_in,
    output logic [NSEL-1:0]   sel_n,
    output logic [GPL_W-1:0]  gpl,
    output logic [PH_W-1:0]   qphase,
    output logic              busy,
    output logic              done
);
    logic [PH_W-1:0]   ph_q;
    st_t               st_q;
    ctl_word_t         cur_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;

    logic              wait_s;
    logic              avail;
    logic [IDX_W-1:0]  grant_idx;
    logic [IDX_W-1:0]  raddr;
    logic [WORD_W-1:0] rdata;
    logic [NSRC-1:0]   req_vec;

    logic boundary, running, hold, take, advance, finish;
    logic unused_rsv;

    assign boundary = (ph_q == PH_W'(NPH - 1));
    assign running  = (st_q == ST_RUN);
    assign hold     = cur_q.waen & wait_s;
    assign take     = !running & boundary & avail;
    assign advance  = running & boundary & !hold & !cur_q.last;
    assign finish   = running & boundary & !hold & cur_q.last;
    assign raddr    = take ? grant_idx : idx_q + IDX_W'(1);

    always_comb begin
        req_vec          = '0;
        req_vec[SRC_EXC] = req_exc;
        req_vec[SRC_TMR] = req_tmr;
        req_vec[SRC_SW]  = sw_run;
        req_vec[SRC_MEM] = req_mem;
    end

    pinseq_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr_en & !running),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    pinseq_arb #(.IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req_vec),
        .sw_idx_in (sw_idx),
        .start_exc (start_exc),
        .start_tmr (start_tmr),
        .start_mem (start_mem),
        .take      (take),
        .avail     (avail),
        .start_idx (grant_idx)
    );

    pinseq_sync #(.STAGES(2)) u_wsync (
        .clk (clk),
        .rst (rst),
        .d   (wait_in),
        .q   (wait_s)
    );

    // NPH is a power of two, so the phase counter wraps on its own
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_q + PH_W'(1);
            done_q <= finish;
            if (take) begin
                st_q  <= ST_RUN;
                idx_q <= grant_idx;
                cur_q <= ctl_word_t'(rdata);
            end else if (advance) begin
                idx_q <= raddr;
                cur_q <= ctl_word_t'(rdata);
            end else if (finish) begin
                st_q <= ST_IDLE;
            end
        end
    end

    assign unused_rsv = ^cur_q.rsv;

    assign sel_n  = running ? sel_slice(cur_q, ph_q) : '1;
    assign gpl    = running ? cur_q.gpl : '0;
    assign qphase = ph_q;
    assign busy   = running;
    assign done   = done_q;

endmodule

// File: rtl/pinseq_engine_chk.sv
module pinseq_engine_chk
    import pinseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NSEL-1:0]  sel_n,
    input logic [GPL_W-1:0] gpl,
    input logic [PH_W-1:0]  qphase,
    input logic             busy,
    input logic             done
);
    p_idle_rest_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sel_n == '1 && gpl == '0));

    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> qphase == PH_W'($past(qphase) + PH_W'(1)));

    p_run_starts_phase0_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> qphase == '0);

    p_word_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && qphase != '0) |-> $stable(gpl));

    p_done_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind pinseq_engine pinseq_engine_chk u_chk (.*);

// File: tb/pinseq_engine_test.sv
module pinseq_engine_test;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        req_exc = 1'b0, req_tmr = 1'b0, sw_run = 1'b0, req_mem = 1'b0;
    logic [5:0]  sw_idx = '0, start_exc = '0, start_tmr = '0, start_mem = '0;
    logic        wait_in = 1'b0;
    logic [3:0]  sel_n;
    logic [11:0] gpl;
    logic [1:0]  qphase;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    logic [31:0] mdl [64];

    always #(CLK_PER/2) clk = ~clk;

    pinseq_engine uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_exc(req_exc), .req_tmr(req_tmr), .sw_run(sw_run), .sw_idx(sw_idx),
        .req_mem(req_mem), .start_exc(start_exc), .start_tmr(start_tmr),
        .start_mem(start_mem), .wait_in(wait_in), .sel_n(sel_n), .gpl(gpl),
        .qphase(qphase), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        logic [15:0] s;
        logic [11:0] g;
        s = 16'(i * 40503) ^ 16'h5A5A;
        g = 12'(i * 945 + 7);
        return {2'(i), 1'(i % 5 == 4), 1'(i % 3 == 0), g, s};
    endfunction

    function automatic logic [3:0] exp_sel(input logic [31:0] w, input int p);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = w[4*i + p];
        return r;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sw_go(input int a);
        @(negedge clk);
        sw_run = 1'b1; sw_idx = 6'(a);
        @(negedge clk);
        sw_run = 1'b0;
    endtask

    // Follows one run word by word; hold_at picks the word that sees wait
    task automatic expect_run(input int start, input int hold_at, input int raise_ph,
                              input int shows_at_hold, input bit poke, input string tag);
        int idx;
        int g;
        logic [31:0] w;
        idx = start;
        g = 0;
        while (busy !== 1'b1 && g < 64) begin
            @(negedge clk);
            g++;
        end
        chk(busy === 1'b1, "R4 run start", 32'(busy), 1);
        for (int n = 0; n < 80; n++) begin
            int shows;
            w = mdl[idx];
            shows = (n == hold_at) ? shows_at_hold : 1;
            for (int s = 0; s < shows; s++) begin
                for (int p = 0; p < 4; p++) begin
                    if (n == hold_at && s == 0 && p == raise_ph) wait_in = 1'b1;
                    if (n == hold_at && shows > 1 && s == shows - 1 && p == 0) wait_in = 1'b0;
                    if (hold_at >= 0 && n == hold_at + 1 && s == 0 && p == 0) wait_in = 1'b0;
                    if (poke && n == 0 && s == 0 && p == 1) begin
                        wr_en = 1'b1; wr_addr = 6'd30; wr_data = 32'hFFFF_FFFF; req_mem = 1'b1;
                    end
                    if (poke && n == 0 && s == 0 && p == 2) begin
                        wr_en = 1'b0; req_mem = 1'b0;
                    end
                    chk(sel_n == exp_sel(w, p), tag, 32'(sel_n), 32'(exp_sel(w, p)));
                    chk(gpl == w[27:16], tag, 32'(gpl), 32'(w[27:16]));
                    chk(qphase == 2'(p), "R3 phase", 32'(qphase), 32'(p));
                    @(negedge clk);
                end
            end
            if (w[29]) break;
            idx = (idx + 1) % 64;
        end
        wait_in = 1'b0;
        chk(!busy && done, "R5 end of run", {busy, done}, 32'b01);
        @(negedge clk);
        chk(!done, "R5 done width", 32'(done), 0);
    endtask

    initial begin
        #(CLK_PER * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R2 / R3: reset state
        chk(sel_n == 4'hF, "R2 idle select", 32'(sel_n), 32'hF);
        chk(gpl == 12'h0, "R2 idle gpl", 32'(gpl), 0);
        chk(!busy && !done, "R2 idle flags", {busy, done}, 0);
        chk(qphase == 2'd0, "R3 reset phase", 32'(qphase), 0);

        for (int i = 0; i < 64; i++) begin
            mdl[i] = pat(i);
            wr(i, mdl[i]);
        end

        // R1 R4 R5 R10: software run from every index, wrap at 63
        for (int s = 0; s < 64; s++) begin
            sw_go(s);
            expect_run(s, -1, 0, 1, 1'b0, "R1 sweep");
        end

        // R8: all four at once, served exc, tmr, sw, mem
        @(negedge clk);
        start_exc = 6'd7; start_tmr = 6'd22; start_mem = 6'd51; sw_idx = 6'd33;
        req_exc = 1'b1; req_tmr = 1'b1; req_mem = 1'b1; sw_run = 1'b1;
        @(negedge clk);
        req_exc = 1'b0; req_tmr = 1'b0; req_mem = 1'b0; sw_run = 1'b0;
        expect_run(7, -1, 0, 1, 1'b0, "R8 exception first");
        expect_run(22, -1, 0, 1, 1'b0, "R8 timer second");
        expect_run(33, -1, 0, 1, 1'b0, "R8 software third");
        expect_run(51, -1, 0, 1, 1'b0, "R8 memory last");

        // R9: write during run ignored; memory request raised mid-run waits
        sw_go(10);
        expect_run(10, -1, 0, 1, 1'b1, "R9 run with poke");
        expect_run(51, -1, 0, 1, 1'b0, "R8 pending mem");
        sw_go(30);
        expect_run(30, -1, 0, 1, 1'b0, "R9 word kept");

        // R9 R10: idle write accepted, reserved bits set
        mdl[30] = (pat(30) ^ 32'h0000_F0F0) | 32'hE000_0000;
        wr(30, mdl[30]);
        sw_go(30);
        expect_run(30, -1, 0, 1, 1'b0, "R9 R10 new word");

        // R6: waits on wait-enabled words 15 and 18
        sw_go(15);
        expect_run(15, 0, 0, 3, 1'b0, "R6 hold three");
        sw_go(15);
        expect_run(15, 3, 1, 2, 1'b0, "R6 raise three clocks early");
        sw_go(15);
        expect_run(15, 3, 2, 1, 1'b0, "R6 raise two clocks early");

        // R7: wait high over words without wait-enable
        for (int i = 40; i < 44; i++) begin
            mdl[i] = pat(i) & ~32'h3000_0000;
            if (i == 43) mdl[i] = mdl[i] | 32'h2000_0000;
            wr(i, mdl[i]);
        end
        wait_in = 1'b1;
        sw_go(40);
        expect_run(40, -1, 0, 1, 1'b0, "R7 wait ignored");

        repeat (6) @(negedge clk);
        chk(!busy && sel_n == 4'hF, "R2 rest after runs", {busy, sel_n}, 32'h0F);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule